// File: doc/BRIEF.md
# Immediate and Variable Bit Shifter

This block is the shift unit of a small 8-bit machine that has two working registers, R0 and R1, and a carry flag C. Each cycle it takes an opcode together with the current R0, R1 and C. It decodes three opcode families:

- shifts by an immediate length to the left;
- shifts by an immediate length to the right;
- a shift of R0 by the amount held in R1.

Each shift runs in logical mode or in circular (rotate) mode. One clock edge later it presents the new R0, R1 and C values, and a write enable for each register.

An opcode outside these families leaves the enables low and returns the register and flag values unchanged. Instruction fetch, sequencing and the other arithmetic operations are handled elsewhere.

Top module: `shf_unit`

## Requirements
- R1: Opcode bits 7:5 = 110 select an immediate left shift. Bit 4 selects the target register (0 = R0, 1 = R1). Bit 3 selects the mode (0 = logical, 1 = circular). Bits 2:0 give the length, 0 to 7. Only the target register's write enable rises.
- R2: Opcode bits 7:5 = 101 select an immediate right shift. It uses the same register, mode and length fields as R1.
- R3: A logical shift fills the vacated bit positions with zeros. A circular shift feeds each bit that leaves one end back in at the other end.
- R4: Opcode bits 7:2 = 111011 select a variable shift of R0 by the unsigned value in R1. Bit 1 gives the direction (0 = right, 1 = left) and bit 0 gives the mode (0 = logical, 1 = circular). The result is written to R0 only.
- R5: During a variable shift, if R1 is greater than 8, the new R0 is zero in every mode and direction.
- R6: During a variable shift, R1 = 8 gives zero in logical mode and leaves the operand unchanged in circular mode. R1 = 0 leaves the operand unchanged in both modes.
- R7: After a variable shift, C is 1 exactly when the new R0 is zero.
- R8: An immediate shift never changes C. A length of 0 leaves the target register unchanged.
- R9: Any other opcode raises no write enable and passes R0, R1 and C through unchanged.
- R10: All outputs are registered with a latency of one cycle. While the synchronous reset is high, all outputs and both enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 8 | Instruction byte |
| r0_in | input | 8 | Current R0 |
| r1_in | input | 8 | Current R1 |
| c_in | input | 1 | Current carry flag |
| r0_out | output | 8 | New R0 value |
| r1_out | output | 8 | New R1 value |
| c_out | output | 1 | New carry flag |
| r0_we | output | 1 | R0 write enable |
| r1_we | output | 1 | R1 write enable |

## Verification
The assertions compare each registered output with the inputs of the previous cycle. They therefore assume that opcode, R0, R1 and C are stable and known at every sampled edge once reset has been released. They also skip the first edge after reset, using an internal flag that marks when the output registers hold real results.

The bench drives a new vector on each falling edge and checks the outputs one full cycle later, so every input sits steady across the capturing edge. The sweep covers all 256 opcodes, eight R0 patterns and R1 values from 0 to 10 plus two large values. This reaches the over-range rule and the exact-8 boundary in both directions and both modes.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int unsigned OPC_W  = 8;
    localparam int unsigned LEN_W  = 3;

    localparam logic [2:0] PFX_LEFT  = 3'b110;
    localparam logic [2:0] PFX_RIGHT = 3'b101;
    localparam logic [5:0] PFX_VAR   = 6'b111011;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_IMM  = 2'd1,
        K_VAR  = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic             dst_r1;
        logic             circ;
        logic             left;
        logic [LEN_W-1:0] len;
    } dec_t;

    function automatic dec_t decode_op(input logic [OPC_W-1:0] op);
        dec_t d;
        d = '0;
        d.kind = K_NONE;
        if (op[7:5] == PFX_LEFT || op[7:5] == PFX_RIGHT) begin
            d.kind   = K_IMM;
            d.left   = (op[7:5] == PFX_LEFT);
            d.dst_r1 = op[4];
            d.circ   = op[3];
            d.len    = op[LEN_W-1:0];
        end else if (op[7:2] == PFX_VAR) begin
            d.kind   = K_VAR;
            d.left   = op[1];
            d.circ   = op[0];
            d.dst_r1 = 1'b0;
        end
        return d;
    endfunction

endpackage

// File: rtl/shf_decode.sv
module shf_decode
    import shf_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);
    always_comb begin
        dec = decode_op(opcode);
    end
endmodule

// File: rtl/shf_core.sv
module shf_core #(
    parameter int unsigned W  = 8,
    parameter int unsigned AW = $clog2(W) + 1
) (
    input  logic [W-1:0]  operand,
    input  logic [AW-1:0] amt,
    input  logic          left,
    input  logic          circ,
    output logic [W-1:0]  result
);
    logic [W-1:0] mirrored;
    logic [W-1:0] oriented;
    logic [W-1:0] stage [0:AW];

    // Left shifts reuse the right-shift chain on a bit-reversed operand.
    for (genvar b = 0; b < W; b++) begin : g_mirror_in
        assign mirrored[b] = operand[W-1-b];
    end
    assign oriented = left ? mirrored : operand;
    assign stage[0] = oriented;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int unsigned SH  = 1 << k;
        localparam int unsigned ROT = SH % W;
        logic [W-1:0] moved;
        if (SH < W) begin : g_inrange
            assign moved = circ ? {stage[k][ROT-1:0], stage[k][W-1:ROT]}
                                : (stage[k] >> SH);
        end else if (ROT == 0) begin : g_whole
            assign moved = circ ? stage[k] : '0;
        end else begin : g_wrap
            assign moved = circ ? {stage[k][ROT-1:0], stage[k][W-1:ROT]} : '0;
        end
        assign stage[k+1] = amt[k] ? moved : stage[k];
    end

    logic [W-1:0] unmirrored;
    for (genvar b = 0; b < W; b++) begin : g_mirror_out
        assign unmirrored[b] = stage[AW][W-1-b];
    end
    assign result = left ? unmirrored : stage[AW];

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic [W-1:0]     r0_in,
    input  logic [W-1:0]     r1_in,
    input  logic             c_in,
    output logic [W-1:0]     r0_out,
    output logic [W-1:0]     r1_out,
    output logic             c_out,
    output logic             r0_we,
    output logic             r1_we
);
    localparam int unsigned AW = $clog2(W) + 1;

    dec_t         dec;
    logic [W-1:0] operand;
    logic [AW-1:0] amt;
    logic         over;
    logic [W-1:0] shifted;
    logic [W-1:0] res;
    logic [W-1:0] n_r0, n_r1;
    logic         n_c, n_we0, n_we1;
    logic         valid_q;

    shf_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    always_comb begin
        over    = (dec.kind == K_VAR) && (r1_in > W[W-1:0]);
        operand = (dec.kind == K_IMM && dec.dst_r1) ? r1_in : r0_in;
        if (dec.kind == K_VAR)
            amt = r1_in[AW-1:0];
        else
            amt = AW'(dec.len);
    end

    shf_core #(.W(W), .AW(AW)) u_core (
        .operand (operand),
        .amt     (amt),
        .left    (dec.left),
        .circ    (dec.circ),
        .result  (shifted)
    );

    assign res = over ? '0 : shifted;

    always_comb begin
        n_r0  = r0_in;
        n_r1  = r1_in;
        n_c   = c_in;
        n_we0 = 1'b0;
        n_we1 = 1'b0;
        case (dec.kind)
            K_IMM: begin
                if (dec.dst_r1) begin
                    n_r1  = res;
                    n_we1 = 1'b1;
                end else begin
                    n_r0  = res;
                    n_we0 = 1'b1;
                end
            end
            K_VAR: begin
                n_r0  = res;
                n_we0 = 1'b1;
                n_c   = (res == '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r0_out  <= '0;
            r1_out  <= '0;
            c_out   <= 1'b0;
            r0_we   <= 1'b0;
            r1_we   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            r0_out  <= n_r0;
            r1_out  <= n_r1;
            c_out   <= n_c;
            r0_we   <= n_we0;
            r1_we   <= n_we1;
            valid_q <= 1'b1;
        end
    end

    // R1 R2 R4: at most one register is written per cycle
    a_r1_single_we: assert property (@(posedge clk) disable iff (rst)
        $onehot0({r0_we, r1_we}));

    a_r4_var_writes_r0: assert property (@(posedge clk) disable iff (rst)
        valid_q && $past(dec.kind) == K_VAR |-> r0_we && !r1_we);

    a_r5_overrange_zero: assert property (@(posedge clk) disable iff (rst)
        valid_q && $past(dec.kind) == K_VAR && $past(r1_in) > W[W-1:0]
        |-> r0_out == '0 && c_out);

    a_r7_zero_carry: assert property (@(posedge clk) disable iff (rst)
        valid_q && $past(dec.kind) == K_VAR |-> c_out == (r0_out == '0));

    a_r8_imm_keeps_c: assert property (@(posedge clk) disable iff (rst)
        valid_q && $past(dec.kind) == K_IMM |-> c_out == $past(c_in));

    a_r3_rotate_popcount: assert property (@(posedge clk) disable iff (rst)
        valid_q && $past(dec.kind) != K_NONE && $past(dec.circ) && !$past(over)
        |-> $countones(r0_we ? r0_out : r1_out) == $countones($past(operand)));

    a_r9_passthrough: assert property (@(posedge clk) disable iff (rst)
        valid_q && $past(dec.kind) == K_NONE
        |-> !r0_we && !r1_we && r0_out == $past(r0_in)
            && r1_out == $past(r1_in) && c_out == $past(c_in));

endmodule

// File: tb/shf_unit_bench.sv
module shf_unit_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] opcode, r0_in, r1_in;
    logic       c_in;
    logic [7:0] r0_out, r1_out;
    logic       c_out, r0_we, r1_we;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    shf_unit u_shf_unit (
        .clk(clk), .rst(rst), .opcode(opcode), .r0_in(r0_in), .r1_in(r1_in),
        .c_in(c_in), .r0_out(r0_out), .r1_out(r1_out), .c_out(c_out),
        .r0_we(r0_we), .r1_we(r1_we)
    );

    function automatic logic [7:0] ref_shift(input logic [7:0] x, input int n,
                                             input bit left, input bit circ);
        logic [15:0] w;
        w = {8'h00, x};
        if (left)
            return circ ? 8'(((w << n) | (w >> (8 - n))) & 16'hFF) : 8'((w << n) & 16'hFF);
        else
            return circ ? 8'(((w >> n) | (w << (8 - n))) & 16'hFF) : 8'(w >> n);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%h r0=%h r1=%h c=%b actual=%h expected=%h",
                     tag, opcode, r0_in, r1_in, c_in, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] pats [8];
        logic [7:0] r1s  [13];
        pats = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'hA5, 8'h3C, 8'h96, 8'h7E};
        r1s  = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8,
                 8'd9, 8'd10, 8'd200, 8'd255};
        rst = 1'b1; opcode = 8'hC3; r0_in = 8'h5A; r1_in = 8'h07; c_in = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset outputs", {r0_out, r1_out, c_out, r0_we, r1_we}, 32'h0);
        rst = 1'b0;
        for (int op = 0; op < 256; op++) begin
            for (int pi = 0; pi < 8; pi++) begin
                for (int ri = 0; ri < 13; ri++) begin
                    logic [7:0] e0, e1, x;
                    logic       ec, ew0, ew1, left, circ;
                    int         n;
                    string      tag, ctag;
                    opcode = 8'(op);
                    r0_in  = pats[pi];
                    r1_in  = r1s[ri] ^ ((op[4] && r1s[ri] < 8) ? 8'h00 : 8'h00);
                    if (op[7:5] == 3'b110 || op[7:5] == 3'b101) r1_in = pats[(pi + ri) % 8];
                    c_in   = ((op + pi + ri) % 2) == 1;
                    e0 = r0_in; e1 = r1_in; ec = c_in; ew0 = 0; ew1 = 0;
                    tag = "R9"; ctag = "R9";
                    if (op[7:5] == 3'b110 || op[7:5] == 3'b101) begin
                        // R1 R2: fields R=bit4, M=bit3, length=bits2:0
                        left = (op[7:5] == 3'b110);
                        circ = op[3];
                        n    = op[2:0];
                        x    = op[4] ? r1_in : r0_in;
                        if (op[4]) begin e1 = ref_shift(x, n, left, circ); ew1 = 1; end
                        else       begin e0 = ref_shift(x, n, left, circ); ew0 = 1; end
                        tag  = left ? "R1 R3" : "R2 R3";
                        if (n == 0) tag = {tag, " R8 len0"};
                        ctag = "R8 carry";
                    end else if (op[7:2] == 6'b111011) begin
                        // R4: D=bit1 (1 left), M=bit0 (1 circular)
                        left = op[1];
                        circ = op[0];
                        n    = r1_in;
                        ew0  = 1;
                        if (n > 8) begin e0 = 8'h00; tag = "R5"; end
                        else begin
                            e0  = ref_shift(r0_in, n, left, circ);
                            tag = (n == 8 || n == 0) ? "R4 R6" : "R4 R3";
                        end
                        ec   = (e0 == 8'h00);
                        ctag = "R7";
                    end
                    @(posedge clk);
                    @(negedge clk);
                    // R10: results appear one edge after the inputs
                    chk({tag, " value"}, {16'h0, r0_out, r1_out}, {16'h0, e0, e1});
                    chk({tag, " enables"}, {30'h0, r0_we, r1_we}, {30'h0, ew0, ew1});
                    chk(ctag, {31'h0, c_out}, {31'h0, ec});
                end
            end
        end
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 reset again", {r0_out, r1_out, c_out, r0_we, r1_we}, 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule